// File: doc/BRIEF.md
# Upper Port Pin Function Selector

This block decides what four upper port pins present to the outside world. After reset all four behave as ordinary latched port outputs: a local port write stores a nibble, and each pin shows its stored bit. Two one-shot commands widen what the pins can do. The flag command turns the two lowest pins into host interrupt lines. One shows the output-buffer-full status and the other shows the inverted input-buffer-full status. The DMA command turns the third pin into a DMA request line.

Once a pin has a special function, the port bit written to it acts as a gate or a trigger rather than as a level. In flag mode a stored 1 lets the status reach the pin and a stored 0 forces the pin low. In DMA mode writing a 1 raises the request. The request drops at the trailing (rising) edge of a host read or write strobe that was qualified by the active-low acknowledge input. It also drops when the DMA command is issued again. The mode bits never clear except by reset.

The asynchronous active-low reset is released through a two-stage synchronizer, so internal state leaves reset two clock edges after `rst_n` rises.

Top module: `pin_func_mux`

## Requirements
- R1: Two clock edges after reset release, `pins_o` equals 4'b1111: the port latch resets to all ones, and no special function is active.
- R2: While neither mode is enabled, a port write makes `pins_o` equal `port_wdata` after the next clock edge. The status inputs, host strobes and acknowledge input have no effect on the pins.
- R3: The flag mode and the DMA mode are each set by a one-cycle command strobe and stay set until reset. Issuing one command does not change the other mode.
- R4: In flag mode, `pins_o[0]` equals stored port bit 0 AND `obf`, combinationally. A stored 0 holds the pin low.
- R5: In flag mode, `pins_o[1]` equals stored port bit 1 AND NOT `ibf`, combinationally. A stored 0 holds the pin low.
- R6: In DMA mode, `pins_o[2]` shows the request flag, which is 0 when the mode is entered. A port write with `port_wdata[2]`=1 sets it at the next edge. A port write with bit 2 = 0 leaves it unchanged.
- R7: The request clears at the clock edge that first samples `host_rd_n` high after low, provided `dack_n` was sampled low at the previous edge. While the read strobe is still low, the request stays set.
- R8: The same trailing-edge clear as R7 applies to `host_wr_n`.
- R9: A host strobe whose trailing edge is seen while `dack_n` was sampled high does not clear the request.
- R10: An `en_dma_cmd` strobe clears the request at the next edge, and this clear wins over a port write setting it in the same cycle.
- R11: `pins_o[3]` always shows stored port bit 3. A pin whose mode is not enabled shows its stored port bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Local port write strobe, one cycle |
| port_wdata | input | 4 | Port write nibble, bit 0 maps to pin 0 |
| en_flags_cmd | input | 1 | Flag-mode enable command strobe |
| en_dma_cmd | input | 1 | DMA-mode enable command strobe |
| ibf | input | 1 | Input buffer full status |
| obf | input | 1 | Output buffer full status |
| dack_n | input | 1 | DMA acknowledge, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| pins_o | output | 4 | Pin values, bit 0 = buffer-full flag pin, bit 3 = acknowledge pin |

## Verification
A lost mode bit shows at once: the flag pins fall back to the stored port bits, or the request pin shows the stored bit 2 in the first cycle after the bit is lost. A wrong request flag shows on `pins_o[2]` the cycle after the edge that should have set or cleared it. Clears at the wrong strobe edge, or clears that ignore the acknowledge input, are therefore caught by holding the strobe low across several cycles and by repeating the access with `dack_n` high. A wrong polarity on either flag pin shows combinationally the moment the status input toggles.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int unsigned PIN_CNT  = 4;
  localparam int unsigned IDX_OBF  = 0;
  localparam int unsigned IDX_IBF  = 1;
  localparam int unsigned IDX_DRQ  = 2;
  localparam int unsigned IDX_ACK  = 3;
  localparam logic [PIN_CNT-1:0] PORT_RST_VAL = '1;

  typedef struct packed {
    logic flags;
    logic dma;
  } pin_mode_t;
endpackage

// File: rtl/pin_rst_sync.sv
module pin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pin_mode_reg.sv
module pin_mode_reg
  import pinmux_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_flags,
  input  logic      set_dma,
  output pin_mode_t mode_o
);
  pin_mode_t mode_q;
  pin_mode_t mode_d;
  logic      mode_en;

  always_comb begin
    mode_en     = set_flags | set_dma;
    mode_d      = mode_q;
    mode_d.flags = mode_q.flags | set_flags;
    mode_d.dma   = mode_q.dma   | set_dma;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pin_port_latch.sv
module pin_port_latch #(
  parameter int unsigned         W       = 4,
  parameter logic [W-1:0]        RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= wdata;
  end

  assign q_o = q;
endmodule

// File: rtl/pin_drq_ctrl.sv
module pin_drq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic port_wr,
  input  logic req_bit,
  input  logic rearm,
  input  logic host_rd_n,
  input  logic host_wr_n,
  input  logic dack_n,
  output logic drq_o
);
  logic rd_q, wr_q, ack_q;
  logic drq_q, drq_d;
  logic rd_trail, wr_trail, ack_hit, req_set;

  always_comb begin
    rd_trail = ~rd_q & host_rd_n;
    wr_trail = ~wr_q & host_wr_n;
    ack_hit  = (rd_trail | wr_trail) & ~ack_q;
    req_set  = dma_en & port_wr & req_bit;
    drq_d    = drq_q;
    if (req_set)           drq_d = 1'b1;
    if (ack_hit || rearm)  drq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
      ack_q <= 1'b1;
      drq_q <= 1'b0;
    end else begin
      rd_q  <= host_rd_n;
      wr_q  <= host_wr_n;
      ack_q <= dack_n;
      drq_q <= drq_d;
    end
  end

  assign drq_o = drq_q;
endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux
  import pinmux_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_wr,
  input  logic [PIN_CNT-1:0] port_wdata,
  input  logic               en_flags_cmd,
  input  logic               en_dma_cmd,
  input  logic               ibf,
  input  logic               obf,
  input  logic               dack_n,
  input  logic               host_rd_n,
  input  logic               host_wr_n,
  output logic [PIN_CNT-1:0] pins_o
);
  logic               rst_n_int;
  pin_mode_t          mode;
  logic               flags_en;
  logic               dma_en;
  logic [PIN_CNT-1:0] port_q;
  logic               drq;

  pin_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_n_int)
  );

  pin_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .set_flags(en_flags_cmd),
    .set_dma  (en_dma_cmd),
    .mode_o   (mode)
  );

  assign flags_en = mode.flags;
  assign dma_en   = mode.dma;

  pin_port_latch #(.W(PIN_CNT), .RST_VAL(PORT_RST_VAL)) u_port (
    .clk  (clk),
    .rst_n(rst_n_int),
    .wr_en(port_wr),
    .wdata(port_wdata),
    .q_o  (port_q)
  );

  pin_drq_ctrl u_drq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .dma_en   (dma_en),
    .port_wr  (port_wr),
    .req_bit  (port_wdata[IDX_DRQ]),
    .rearm    (en_dma_cmd),
    .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n),
    .dack_n   (dack_n),
    .drq_o    (drq)
  );

  always_comb begin
    pins_o = port_q;
    if (flags_en) begin
      pins_o[IDX_OBF] = port_q[IDX_OBF] & obf;
      pins_o[IDX_IBF] = port_q[IDX_IBF] & ~ibf;
    end
    if (dma_en) begin
      pins_o[IDX_DRQ] = drq;
    end
  end
endmodule

// File: rtl/pin_func_mux_chk.sv
module pin_func_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flags_en,
  input logic       dma_en,
  input logic       port_wr,
  input logic [3:0] port_wdata,
  input logic       en_flags_cmd,
  input logic       en_dma_cmd,
  input logic       ibf,
  input logic       obf,
  input logic       dack_n,
  input logic       host_rd_n,
  input logic       host_wr_n,
  input logic [3:0] pins_o
);
  logic rd_prev, wr_prev, ack_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev  <= 1'b1;
      wr_prev  <= 1'b1;
      ack_prev <= 1'b1;
    end else begin
      rd_prev  <= host_rd_n;
      wr_prev  <= host_wr_n;
      ack_prev <= dack_n;
    end
  end

  p_port_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !flags_en && !dma_en && !en_flags_cmd && !en_dma_cmd)
      |=> (pins_o == $past(port_wdata)));

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flags_en |=> flags_en);

  p_obf_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_en && !obf) |-> !pins_o[0]);

  p_ibf_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_en && ibf) |-> !pins_o[1]);

  p_dma_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |=> dma_en);

  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !rd_prev && host_rd_n && !ack_prev) |=> !pins_o[2]);

  p_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !wr_prev && host_wr_n && !ack_prev) |=> !pins_o[2]);

  p_nodack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && pins_o[2] && ack_prev && !en_dma_cmd) |=> pins_o[2]);

  p_rearm_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_dma_cmd |=> !pins_o[2]);

  p_ack_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (pins_o[3] == $past(port_wdata[3])));
endmodule

bind pin_func_mux pin_func_mux_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .flags_en    (flags_en),
  .dma_en      (dma_en),
  .port_wr     (port_wr),
  .port_wdata  (port_wdata),
  .en_flags_cmd(en_flags_cmd),
  .en_dma_cmd  (en_dma_cmd),
  .ibf         (ibf),
  .obf         (obf),
  .dack_n      (dack_n),
  .host_rd_n   (host_rd_n),
  .host_wr_n   (host_wr_n),
  .pins_o      (pins_o)
);

// File: tb/tb_pin_func_mux.sv
module tb_pin_func_mux;
  logic       clk;
  logic       rst_n;
  logic       port_wr;
  logic [3:0] port_wdata;
  logic       en_flags_cmd, en_dma_cmd;
  logic       ibf, obf, dack_n, host_rd_n, host_wr_n;
  logic [3:0] pins_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  pin_func_mux dut (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
    .en_flags_cmd(en_flags_cmd), .en_dma_cmd(en_dma_cmd), .ibf(ibf), .obf(obf),
    .dack_n(dack_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .pins_o(pins_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; port_wr = 0; port_wdata = '0; en_flags_cmd = 0; en_dma_cmd = 0;
    ibf = 0; obf = 0; dack_n = 1; host_rd_n = 1; host_wr_n = 1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic pwrite(input logic [3:0] v);
    port_wr = 1; port_wdata = v; step(); port_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset pins", pins_o, 4'b1111);
    ibf = 1; obf = 0; step();
    chk("R1 reset pins ignore status", pins_o, 4'b1111);
  endtask

  task automatic t_port();
    do_reset();
    pwrite(4'b0101);
    chk("R2 port write", pins_o, 4'b0101);
    obf = 1; ibf = 1; dack_n = 0; host_rd_n = 0; step();
    host_rd_n = 1; host_wr_n = 0; step(); host_wr_n = 1; dack_n = 1; step();
    chk("R2 port ignores status and strobes", pins_o, 4'b0101);
    pwrite(4'b1010);
    chk("R11 port bit3 and others", pins_o, 4'b1010);
  endtask

  task automatic t_flags();
    do_reset();
    pwrite(4'b1011);
    en_flags_cmd = 1; step(); en_flags_cmd = 0;
    obf = 1; ibf = 0; #1;
    chk("R4/R5 flags obf=1 ibf=0", pins_o, 4'b1011);
    obf = 0; #1;
    chk("R4 obf low drives pin0 low", pins_o, 4'b1010);
    ibf = 1; #1;
    chk("R5 ibf high drives pin1 low", pins_o, 4'b1000);
    obf = 1; ibf = 0; pwrite(4'b0100);
    chk("R4/R5 stored zero holds flag pins low, R11 upper pins port", pins_o, 4'b0100);
    repeat (5) step();
    pwrite(4'b0011);
    chk("R3 flag mode sticky", pins_o, 4'b0011);
    obf = 0; ibf = 1; #1;
    chk("R3 flag mode still gating", pins_o, 4'b0000);
  endtask

  task automatic t_dma_set();
    do_reset();
    pwrite(4'b1111);
    en_dma_cmd = 1; step(); en_dma_cmd = 0;
    chk("R6 request low on entry", pins_o, 4'b1011);
    pwrite(4'b1011);
    chk("R6 bit2=0 leaves request low", pins_o, 4'b1011);
    pwrite(4'b0100);
    chk("R6 bit2=1 sets request, R11 bit3", pins_o, 4'b0100);
    pwrite(4'b0001);
    chk("R6 bit2=0 keeps request set", pins_o, 4'b0101);
    obf = 0; ibf = 1; #1;
    chk("R11 flag pins stay port pins in DMA-only mode", pins_o, 4'b0101);
    repeat (4) step();
    chk("R3 DMA mode sticky", pins_o[2:2], 1'b1);
  endtask

  task automatic t_rd_clear();
    host_rd_n = 0; step(); host_rd_n = 1; step();
    chk("R9 read without ack keeps request", {3'b0, pins_o[2]}, 4'b0001);
    dack_n = 0; host_rd_n = 0; step(); step();
    chk("R7 request held while read low", {3'b0, pins_o[2]}, 4'b0001);
    host_rd_n = 1; step();
    chk("R7 read trailing edge clears", {3'b0, pins_o[2]}, 4'b0000);
    dack_n = 1; step();
  endtask

  task automatic t_wr_clear();
    pwrite(4'b0100);
    chk("R6 request set again", {3'b0, pins_o[2]}, 4'b0001);
    host_wr_n = 0; step(); host_wr_n = 1; step();
    chk("R9 write without ack keeps request", {3'b0, pins_o[2]}, 4'b0001);
    dack_n = 0; host_wr_n = 0; step();
    chk("R8 request held while write low", {3'b0, pins_o[2]}, 4'b0001);
    host_wr_n = 1; step();
    chk("R8 write trailing edge clears", {3'b0, pins_o[2]}, 4'b0000);
    dack_n = 1; step();
  endtask

  task automatic t_rearm();
    pwrite(4'b0100);
    en_dma_cmd = 1; step(); en_dma_cmd = 0;
    chk("R10 re-issued command clears request", {3'b0, pins_o[2]}, 4'b0000);
    port_wr = 1; port_wdata = 4'b0100; en_dma_cmd = 1; step();
    port_wr = 0; en_dma_cmd = 0;
    chk("R10 clear wins over same-cycle set", {3'b0, pins_o[2]}, 4'b0000);
  endtask

  task automatic t_both();
    do_reset();
    en_flags_cmd = 1; step(); en_flags_cmd = 0;
    en_dma_cmd = 1; step(); en_dma_cmd = 0;
    pwrite(4'b0111);
    obf = 1; ibf = 0; #1;
    chk("R3 both modes active together", pins_o, 4'b0111);
    obf = 0; ibf = 1; #1;
    chk("R4/R5 in combined mode", pins_o, 4'b0100);
  endtask

  initial begin
    t_reset();
    t_port();
    t_flags();
    t_dma_set();
    t_rd_clear();
    t_wr_clear();
    t_rearm();
    t_both();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule